// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the host-facing register port of a peripheral that carries several channels of eight byte-wide registers each. The host bus is asynchronous to the block clock. A static mode input selects how the same group of pins is read. In separate-strobe mode there are two active-low strobes, one for reads and one for writes, and one active-low select per channel. In combined mode the write-strobe pin becomes a direction level, the read-strobe pin has no function, and select bit 0 becomes the single device select. A separate channel-number input picks the channel.

The bidirectional data bus reaches the block as three pad-side signals: incoming byte, outgoing byte and output enable. Read data comes straight from a storage array through the decoded address, so the byte stays valid for as long as the host holds the access open. The strobes pass through a two-flop synchroniser. A small access state machine then turns each access into exactly one single-cycle pulse on a per-register pulse vector. A read pulse follows the start of a read. A write pulse follows the end of a write, and the same pulse commits the captured byte into the array. The mode is expected to change only while reset is held.

States of the access machine:
- `ST_IDLE`: no access.
- `ST_RD_FIRE`: one-cycle read pulse.
- `ST_RD_HOLD`: waits for the read to end.
- `ST_WR_HOLD`: waits for the write to end.
- `ST_WR_FIRE`: one-cycle write pulse and commit.

Transitions:
- idle→rd_fire: synchronised read seen.
- idle→wr_hold: synchronised write seen.
- rd_fire→rd_hold: always.
- rd_hold→idle: read released.
- wr_hold→wr_fire: write released.
- wr_fire→idle: always.

Top module: `hostbus_regport`

## Requirements
- R1: While reset is low and right after it, every stored byte is 0x00, both pulse vectors are zero and `d_oe` is low.
- R2: In separate-strobe mode (`sep_mode`=1), a write is an interval with `wr_n` low while some `cs_n` bit is low. The byte on `d_in` is stored at register `addr` of the selected channel when `wr_n` rises.
- R3: In separate-strobe mode, while `rd_n` and some `cs_n` bit are low, `d_oe` is high and `d_out` carries the stored byte at `addr` of the selected channel.
- R4: In combined mode (`sep_mode`=0), `cs_n[0]` low qualifies an access and `ch_addr` names the channel. `wr_n`=1 means read and drives `d_out`/`d_oe`. `wr_n`=0 means write, which commits when `cs_n[0]` rises.
- R5: In combined mode `rd_n` has no effect: toggling it during a write produces no read pulse and no drive.
- R6: With every `cs_n` bit high, `d_oe` stays low and no pulse is produced, whatever `rd_n` and `wr_n` do.
- R7: Each access produces exactly one pulse, one cycle wide, on bit `channel*8+addr` of `rd_pulse` (reads) or `wr_pulse` (writes). At most one bit of the two vectors is high in any cycle.
- R8: In separate-strobe mode, when several `cs_n` bits are low, the lowest-numbered one selects the channel.
- R9: In combined mode, `cs_n` bits above bit 0 are ignored: with `cs_n[0]` high there is no drive and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sep_mode | input | 1 | 1: separate strobes, 0: combined direction/select |
| cs_n | input | NCH | Per-channel selects; bit 0 is the device select in combined mode |
| ch_addr | input | CHW | Channel number used in combined mode |
| rd_n | input | 1 | Read strobe, active low (separate-strobe mode only) |
| wr_n | input | 1 | Write strobe (separate mode) or direction, 1 = read (combined mode) |
| addr | input | 3 | Register number within a channel |
| d_in | input | 8 | Byte from the host side of the data pad |
| d_out | output | 8 | Byte toward the data pad |
| d_oe | output | 1 | Data pad output enable |
| rd_pulse | output | NCH*8 | Single-cycle read pulse per register |
| wr_pulse | output | NCH*8 | Single-cycle write pulse per register |

## Verification
The hardest situations to reach are those where pins are active that must not count: `rd_n` toggling inside a combined-mode write, upper select bits low in combined mode, and two selects low at once in separate-strobe mode. Each has its own directed task. The task holds the offending pin pattern for several clocks, longer than the synchroniser delay, and counts every pulse bit seen at the ports. Back-to-back accesses to all eight registers in both modes then show that the one-pulse-per-access rule survives consecutive accesses.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
    localparam int unsigned NREG = 8;
    localparam int unsigned AW   = 3;
    localparam int unsigned DW   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRE,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WR_FIRE
    } acc_state_t;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CHW = 2
) (
    input  logic            sep_mode,
    input  logic [NCH-1:0]  cs_n,
    input  logic [CHW-1:0]  ch_addr,
    input  logic            rd_n,
    input  logic            wr_n,
    output logic [CHW-1:0]  ch_idx,
    output logic            rd_raw,
    output logic            wr_raw
);
    logic           sel_any;
    logic [CHW-1:0] prio_ch;

    // lowest-numbered active select wins (descending loop, last hit kept)
    always_comb begin
        prio_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!cs_n[i]) prio_ch = CHW'(i);
        end
    end

    always_comb begin
        if (sep_mode) begin
            sel_any = ~&cs_n;
            ch_idx  = prio_ch;
            rd_raw  = sel_any && !rd_n;
            wr_raw  = sel_any && !wr_n;
        end else begin
            sel_any = !cs_n[0];
            ch_idx  = ch_addr;
            rd_raw  = sel_any && wr_n;
            wr_raw  = sel_any && !wr_n;
        end
    end
endmodule

// File: rtl/hbr_sync2.sv
module hbr_sync2 #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/hbr_fsm.sv
module hbr_fsm
    import hbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    output logic fire_rd,
    output logic fire_wr
);
    acc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_s)      state_d = ST_RD_FIRE;
                else if (wr_s) state_d = ST_WR_HOLD;
            end
            ST_RD_FIRE: state_d = ST_RD_HOLD;
            ST_RD_HOLD: if (!rd_s) state_d = ST_IDLE;
            ST_WR_HOLD: if (!wr_s) state_d = ST_WR_FIRE;
            ST_WR_FIRE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fire_rd = 1'b0;
        fire_wr = 1'b0;
        unique case (state_q)
            ST_RD_FIRE: fire_rd = 1'b1;
            ST_WR_FIRE: fire_wr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hbr_store.sv
module hbr_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = 5,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
    import hbr_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned NPULSE = NCH * NREG,
    localparam int unsigned IW = CHW + AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sep_mode,
    input  logic [NCH-1:0]    cs_n,
    input  logic [CHW-1:0]    ch_addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     d_in,
    output logic [DW-1:0]     d_out,
    output logic              d_oe,
    output logic [NPULSE-1:0] rd_pulse,
    output logic [NPULSE-1:0] wr_pulse
);
    logic [CHW-1:0] ch_idx;
    logic           rd_raw, wr_raw;
    logic [1:0]     strobe_s;
    logic           fire_rd, fire_wr;
    logic [IW-1:0]  lat_idx;
    logic [DW-1:0]  lat_data;
    logic [IW-1:0]  live_idx;

    hbr_decode #(.NCH(NCH), .CHW(CHW)) u_decode (
        .sep_mode (sep_mode),
        .cs_n     (cs_n),
        .ch_addr  (ch_addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ch_idx   (ch_idx),
        .rd_raw   (rd_raw),
        .wr_raw   (wr_raw)
    );

    hbr_sync2 #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({wr_raw, rd_raw}),
        .sync_out (strobe_s)
    );

    hbr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_s    (strobe_s[0]),
        .wr_s    (strobe_s[1]),
        .fire_rd (fire_rd),
        .fire_wr (fire_wr)
    );

    assign live_idx = {ch_idx, addr};

    // address and data are captured while the host holds the access open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_idx  <= '0;
            lat_data <= '0;
        end else begin
            if (rd_raw || wr_raw) lat_idx <= live_idx;
            if (wr_raw)           lat_data <= d_in;
        end
    end

    hbr_store #(.DEPTH(NPULSE), .IW(IW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (fire_wr),
        .wr_idx  (lat_idx),
        .wr_data (lat_data),
        .rd_idx  (live_idx),
        .rd_data (d_out)
    );

    assign d_oe = rd_raw;

    for (genvar g = 0; g < int'(NPULSE); g++) begin : g_pulse
        assign rd_pulse[g] = fire_rd && (lat_idx == IW'(g));
        assign wr_pulse[g] = fire_wr && (lat_idx == IW'(g));
    end
endmodule

// File: rtl/hostbus_regport_chk.sv
module hostbus_regport_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned NPULSE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sep_mode,
    input logic [NCH-1:0]    cs_n,
    input logic              d_oe,
    input logic [NPULSE-1:0] rd_pulse,
    input logic [NPULSE-1:0] wr_pulse
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (rd_pulse == '0 && wr_pulse == '0 && !d_oe));

    assert_pulse_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pulse, wr_pulse}));

    assert_rd_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_pulse) |=> !(|rd_pulse));

    assert_wr_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_pulse) |=> !(|wr_pulse));

    assert_no_drive_unselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !d_oe);

    assert_upper_sel_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sep_mode && cs_n[0]) |-> !d_oe);
endmodule

bind hostbus_regport hostbus_regport_chk #(.NCH(NCH), .NPULSE(NPULSE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sep_mode (sep_mode),
    .cs_n     (cs_n),
    .d_oe     (d_oe),
    .rd_pulse (rd_pulse),
    .wr_pulse (wr_pulse)
);

// File: tb/hostbus_regport_test.sv
`timescale 1ns/1ps
module hostbus_regport_test;
    localparam int NCH = 4;
    localparam int NP  = NCH * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sep_mode = 1'b1;
    logic [3:0]    cs_n = 4'hF;
    logic [1:0]    ch_addr = '0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [2:0]    addr = '0;
    logic [7:0]    d_in = '0;
    logic [7:0]    d_out;
    logic          d_oe;
    logic [NP-1:0] rd_pulse, wr_pulse;

    int checks = 0, errors = 0, cycles = 0;
    int rd_cnt = 0, wr_cnt = 0, rd_last = -1, wr_last = -1;
    bit done = 0;

    always #2.5 clk = ~clk;

    hostbus_regport #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .cs_n(cs_n),
        .ch_addr(ch_addr), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        for (int i = 0; i < NP; i++) begin
            if (rd_pulse[i]) begin rd_cnt <= rd_cnt + 1; rd_last <= i; end
            if (wr_pulse[i]) begin wr_cnt <= wr_cnt + 1; wr_last <= i; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; rd_last = -1; wr_last = -1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 0; sep_mode = mode; cs_n = 4'hF; rd_n = 1; wr_n = 1;
        wait_n(3);
        check(d_oe == 0 && rd_pulse == 0 && wr_pulse == 0, "R1 quiet in reset", d_oe, 0);
        rst_n = 1;
        wait_n(2);
    endtask

    function automatic logic [7:0] pat(input int ch, input int a);
        return 8'((ch * 8 + a) * 29 + 3);
    endfunction

    // R2 / R8: separate-mode write with a given select pattern
    task automatic sep_write(input logic [3:0] sel, input int exp_ch, input int a, input logic [7:0] v);
        clr_counts();
        addr = 3'(a); d_in = v; cs_n = sel;
        wait_n(1);
        wr_n = 0;
        wait_n(5);
        check(d_oe == 0, "R2 no drive during write", d_oe, 0);
        wr_n = 1;
        wait_n(1);
        cs_n = 4'hF;
        wait_n(6);
        check(wr_cnt == 1 && rd_cnt == 0, "R7 one write pulse", wr_cnt, 1);
        check(wr_last == exp_ch * 8 + a, "R2 R8 write pulse index", wr_last, exp_ch * 8 + a);
    endtask

    // R3: separate-mode read
    task automatic sep_read(input int ch, input int a, input logic [7:0] exp);
        clr_counts();
        addr = 3'(a); cs_n = ~(4'b1 << ch);
        wait_n(1);
        rd_n = 0;
        wait_n(2);
        check(d_oe == 1, "R3 drive during read", d_oe, 1);
        check(d_out == exp, "R3 read data", d_out, exp);
        wait_n(3);
        rd_n = 1;
        wait_n(1);
        cs_n = 4'hF;
        wait_n(6);
        check(d_oe == 0, "R6 released after read", d_oe, 0);
        check(rd_cnt == 1 && wr_cnt == 0, "R7 one read pulse", rd_cnt, 1);
        check(rd_last == ch * 8 + a, "R7 read pulse index", rd_last, ch * 8 + a);
    endtask

    // R4 / R5: combined-mode write, optionally toggling rd_n
    task automatic cmb_write(input int ch, input int a, input logic [7:0] v, input bit wiggle);
        clr_counts();
        addr = 3'(a); d_in = v; ch_addr = 2'(ch); wr_n = 0;
        wait_n(1);
        cs_n[0] = 0;
        for (int k = 0; k < 6; k++) begin
            if (wiggle) rd_n = ~rd_n;
            wait_n(1);
            if (wiggle) check(d_oe == 0, "R5 rd_n ignored, no drive", d_oe, 0);
        end
        rd_n = 1;
        cs_n[0] = 1;
        wait_n(1);
        wr_n = 1;
        wait_n(6);
        check(wr_cnt == 1 && rd_cnt == 0, "R4 R5 one write pulse, no read", wr_cnt * 16 + rd_cnt, 16);
        check(wr_last == ch * 8 + a, "R4 write pulse index", wr_last, ch * 8 + a);
    endtask

    task automatic cmb_read(input int ch, input int a, input logic [7:0] exp);
        clr_counts();
        addr = 3'(a); ch_addr = 2'(ch); wr_n = 1;
        wait_n(1);
        cs_n[0] = 0;
        wait_n(2);
        check(d_oe == 1 && d_out == exp, "R4 combined read data", d_out, exp);
        wait_n(3);
        cs_n[0] = 1;
        wait_n(6);
        check(d_oe == 0, "R6 released after combined read", d_oe, 0);
        check(rd_cnt == 1 && rd_last == ch * 8 + a, "R7 combined read pulse", rd_last, ch * 8 + a);
    endtask

    // R6: strobes with no select
    task automatic idle_strobes();
        clr_counts();
        cs_n = 4'hF;
        rd_n = 0; wait_n(5);
        check(d_oe == 0, "R6 no drive without select", d_oe, 0);
        rd_n = 1; wr_n = 0; wait_n(5); wr_n = 1; wait_n(6);
        check(rd_cnt == 0 && wr_cnt == 0, "R6 no pulses without select", rd_cnt + wr_cnt, 0);
    endtask

    // R9: upper selects in combined mode
    task automatic cmb_upper_sel();
        clr_counts();
        cs_n = 4'b0101; wr_n = 1; wait_n(5);
        check(d_oe == 0, "R9 upper select no drive", d_oe, 0);
        wr_n = 0; wait_n(5); cs_n = 4'hF; wait_n(1); wr_n = 1; wait_n(6);
        check(rd_cnt == 0 && wr_cnt == 0, "R9 upper select no pulses", rd_cnt + wr_cnt, 0);
    endtask

    initial begin
        do_reset(1'b1);
        check(d_oe == 0, "R1 bus released after reset", d_oe, 0);
        sep_read(0, 5, 8'h00);
        sep_read(3, 7, 8'h00);
        for (int a = 0; a < 8; a++) sep_write(~(4'b1 << 0), 0, a, pat(0, a));
        for (int a = 0; a < 8; a++) sep_read(0, a, pat(0, a));
        sep_write(4'b1011, 2, 4, 8'hA5);
        sep_read(2, 4, 8'hA5);
        sep_write(4'b0101, 1, 6, 8'h3C);
        sep_read(1, 6, 8'h3C);
        sep_read(3, 6, 8'h00);
        idle_strobes();

        do_reset(1'b0);
        sep_mode = 0;
        cmb_read(0, 0, 8'h00);
        for (int a = 0; a < 8; a++) cmb_write(3, a, pat(3, a), a[0]);
        for (int a = 0; a < 8; a++) cmb_read(3, a, pat(3, a));
        cmb_write(1, 2, 8'h5A, 1'b1);
        cmb_read(1, 2, 8'h5A);
        cmb_upper_sel();
        idle_strobes();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule